// File: doc/BRIEF.md
# Flash In-System Programming Sequencer

This block turns a stream of bytes from a two-wire serial slave front end into flash programming operations. The front end supplies each received byte along with start and stop markers. The block answers every byte with an acknowledge or a not-acknowledge. It recognises two kinds of transaction: command writes and data writes. A command write selects an operating mode and a target array, and loads the page address. A data write loads the low address and then carries either program data or the single dummy byte that starts an erase.

There are two target arrays. The code array is byte-organised, with an 8-bit page and an 8-bit low address. The word array is organised in 16-bit words, with a 7-bit page and a 7-bit low address. Every program or erase holds the block busy for a set number of clock cycles. The busy time is 60 us for a program and 10 ms for an erase, and both are derived from the clock frequency parameter. While busy, the block refuses all bus traffic. A 16-bit CRC accumulates every program byte that the block accepts, so that the host can verify a burst without reading the array back.

Top module: `isp_seq`

## Requirements
- R1: After reset, crc_o is 16'hFFFF, busy_o is 0, and ack_valid_o, prog_o, page_erase_o, full_erase_o and rst_req_o are all 0. The mode holds no operation.
- R2: The first byte after start_i is accepted only when bits 7:2 equal the parameter DEV_ID and bits 1:0 are 2'b10 (command write) or 2'b00 (data write). A rejected first byte is nacked, and every later byte up to the next start_i is nacked too.
- R3: The second byte of a command write is acknowledged and latches the mode from bits 7:3 and the target from bit 0 (1 = word array, 0 = code array). The mode codes are 10100 program, 00110 page erase, 01101 full erase, 11010 CRC clear and 01001 CPU reset. CRC clear sets crc_o to 16'hFFFF. CPU reset raises rst_req_o for exactly one cycle.
- R4: The third byte of a command write is acknowledged and loads the page address. The code array takes all 8 bits. The word array takes bits 6:0 and ignores bit 7. Any fourth or later byte is nacked.
- R5: The second byte of a data write is acknowledged and loads the low address. The code array takes bits 7:0 and the word array takes bits 6:0. This byte never changes crc_o.
- R6: In program mode with the code array selected, each accepted data byte gives a one-cycle prog_o pulse. The pulse carries flash_addr_o = {page, low} and flash_wdata_o = {8'h00, byte}. The low address then increments and wraps from 8'hFF to 8'h00 without changing the page.
- R7: In program mode with the word array selected, data bytes pair up with the high byte first. Only the second byte of a pair produces prog_o. That pulse carries flash_wdata_o = {high, low} and flash_addr_o = {2'b00, page[6:0], low[6:0]}. The low address then increments and wraps within 7 bits.
- R8: In page-erase mode, the first data byte produces page_erase_o with the low address bits forced to 0. In full-erase mode, it produces full_erase_o instead. The byte's value is ignored and it does not feed the CRC.
- R9: A program strobe holds busy_o high for PROG_CYCLES cycles, and an erase strobe holds it high for ERASE_CYCLES cycles, counting from the strobe cycle. A byte presented while busy_o is high is nacked. It causes no strobe, no address step and no CRC update.
- R10: Every data byte accepted in program mode updates crc_o. The update shifts the byte in MSB first using CRC-16 with polynomial 0x1021, with no reflection. Both arrays share the one register.
- R11: ack_valid_o pulses in the cycle after each byte_valid_i and is low otherwise. ack_o is valid while ack_valid_o is high.
- R12: Data bytes in a data write are nacked when the mode is none of program, page erase or full erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start or repeated-start marker |
| stop_i | input | 1 | Stop marker |
| byte_valid_i | input | 1 | Received byte is present |
| byte_i | input | 8 | Received byte |
| ack_valid_o | output | 1 | Response to the previous byte is ready |
| ack_o | output | 1 | 1 = acknowledge, 0 = not-acknowledge |
| busy_o | output | 1 | Flash operation in progress |
| prog_o | output | 1 | Program strobe |
| page_erase_o | output | 1 | Page erase strobe |
| full_erase_o | output | 1 | Whole-array erase strobe |
| tgt_word_o | output | 1 | Selected array (1 = word array) |
| flash_addr_o | output | 16 | Address sent with a strobe |
| flash_wdata_o | output | 16 | Data sent with a program strobe |
| rst_req_o | output | 1 | One-cycle CPU reset request |
| crc_o | output | 16 | Running CRC of accepted program bytes |

## Verification
The bench presents a data byte one cycle after an accepted program byte. A design that did not honour the busy window would acknowledge that byte, step the address or fold the byte into the CRC, and every later address and checksum would then be off by one. The bench drives low addresses of 8'hFF and 7'h7F so the increment must wrap. A carry into the page would show up as a wrong flash_addr_o on the next strobe. The bench also checks three more cases. It checks word pairing: a strobe on the first byte of a pair, or a swapped high and low byte, would corrupt flash_wdata_o. It checks that erase bytes stay out of the CRC. And it checks that command traffic is refused during an erase.

// File: rtl/isp_seq_pkg.sv
package isp_seq_pkg;
  localparam int CODE_PG_W = 8;
  localparam int CODE_LO_W = 8;
  localparam int WORD_PG_W = 7;
  localparam int WORD_LO_W = 7;
  localparam int FADDR_W   = 16;

  localparam logic [4:0] MODE_PROG   = 5'b10100;
  localparam logic [4:0] MODE_PERASE = 5'b00110;
  localparam logic [4:0] MODE_FERASE = 5'b01101;
  localparam logic [4:0] MODE_CLRCRC = 5'b11010;
  localparam logic [4:0] MODE_CPURST = 5'b01001;
  localparam logic [4:0] MODE_NONE   = 5'b00000;

  localparam logic [1:0] XFER_DATA = 2'b00;
  localparam logic [1:0] XFER_CMD  = 2'b10;

  typedef enum logic [1:0] {K_NONE, K_CMD, K_DATA} xfer_kind_e;
endpackage

// File: rtl/isp_busy_timer.sv
module isp_busy_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             busy_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/isp_crc16.sv
module isp_crc16 #(
  parameter logic [15:0] POLY = 16'h1021,
  parameter logic [15:0] SEED = 16'hFFFF
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        upd_i,
  input  logic [7:0]  data_i,
  output logic [15:0] crc_o
);
  logic [15:0] crc_q, crc_nxt;

  always_comb begin
    crc_nxt = crc_q;
    for (int i = 7; i >= 0; i--) begin
      if (crc_nxt[15] ^ data_i[i]) crc_nxt = {crc_nxt[14:0], 1'b0} ^ POLY;
      else                         crc_nxt = {crc_nxt[14:0], 1'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= SEED;
    else if (clr_i)  crc_q <= SEED;
    else if (upd_i)  crc_q <= crc_nxt;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/isp_addr_ctl.sv
module isp_addr_ctl
  import isp_seq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tgt_word_i,
  input  logic               load_page_i,
  input  logic               load_low_i,
  input  logic               step_i,
  input  logic [7:0]         byte_i,
  output logic [FADDR_W-1:0] addr_o,
  output logic [FADDR_W-1:0] erase_addr_o
);
  localparam int CODE_PAD = FADDR_W - CODE_PG_W - CODE_LO_W;
  localparam int WORD_PAD = FADDR_W - WORD_PG_W - WORD_LO_W;

  logic [CODE_PG_W-1:0] page_q;
  logic [CODE_LO_W-1:0] low_q;
  logic [WORD_LO_W-1:0] wlow_inc;

  assign wlow_inc = low_q[WORD_LO_W-1:0] + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      low_q  <= '0;
    end else begin
      if (load_page_i)
        page_q <= tgt_word_i ? CODE_PG_W'(byte_i[WORD_PG_W-1:0]) : byte_i[CODE_PG_W-1:0];
      if (load_low_i)
        low_q <= tgt_word_i ? CODE_LO_W'(byte_i[WORD_LO_W-1:0]) : byte_i[CODE_LO_W-1:0];
      else if (step_i)
        low_q <= tgt_word_i ? CODE_LO_W'(wlow_inc) : low_q + 1'b1;  // wraps, no page carry
    end
  end

  always_comb begin
    if (tgt_word_i) begin
      addr_o       = {{WORD_PAD{1'b0}}, page_q[WORD_PG_W-1:0], low_q[WORD_LO_W-1:0]};
      erase_addr_o = {{WORD_PAD{1'b0}}, page_q[WORD_PG_W-1:0], {WORD_LO_W{1'b0}}};
    end else begin
      addr_o       = {{CODE_PAD{1'b0}}, page_q, low_q};
      erase_addr_o = {{CODE_PAD{1'b0}}, page_q, {CODE_LO_W{1'b0}}};
    end
  end
endmodule

// File: rtl/isp_seq.sv
module isp_seq
  import isp_seq_pkg::*;
#(
  parameter logic [5:0] DEV_ID       = 6'h28,
  parameter int         CLK_HZ       = 50_000_000,
  parameter int         PROG_CYCLES  = (CLK_HZ / 1_000_000) * 60,
  parameter int         ERASE_CYCLES = CLK_HZ / 100
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        stop_i,
  input  logic        byte_valid_i,
  input  logic [7:0]  byte_i,
  output logic        ack_valid_o,
  output logic        ack_o,
  output logic        busy_o,
  output logic        prog_o,
  output logic        page_erase_o,
  output logic        full_erase_o,
  output logic        tgt_word_o,
  output logic [15:0] flash_addr_o,
  output logic [15:0] flash_wdata_o,
  output logic        rst_req_o,
  output logic [15:0] crc_o
);
  localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [1:0]         idx_q;
  xfer_kind_e         kind_q;
  logic [4:0]         mode_q;
  logic               tgt_q, half_q;
  logic [7:0]         hi_q;
  logic               accept, take, busy;
  logic               cmd_b2, cmd_b3, low_ld, dat;
  logic               is_prog, is_perase, is_ferase;
  logic               prog_fire, erase_fire, crc_upd, crc_clr;
  logic [FADDR_W-1:0] cur_addr, er_addr;
  logic [CNT_W-1:0]   load_val;

  assign is_prog   = (mode_q == MODE_PROG);
  assign is_perase = (mode_q == MODE_PERASE);
  assign is_ferase = (mode_q == MODE_FERASE);

  always_comb begin
    accept = 1'b0;
    if (!busy) begin
      if (idx_q == 2'd0)
        accept = (byte_i[7:2] == DEV_ID) && (byte_i[1:0] == XFER_DATA || byte_i[1:0] == XFER_CMD);
      else if (kind_q == K_CMD)
        accept = (idx_q != 2'd3);
      else if (kind_q == K_DATA)
        accept = (idx_q == 2'd1) || is_prog || is_perase || is_ferase;
    end
  end

  assign take       = byte_valid_i && !start_i && !stop_i && accept;
  assign cmd_b2     = take && kind_q == K_CMD  && idx_q == 2'd1;
  assign cmd_b3     = take && kind_q == K_CMD  && idx_q == 2'd2;
  assign low_ld     = take && kind_q == K_DATA && idx_q == 2'd1;
  assign dat        = take && kind_q == K_DATA && idx_q == 2'd2;
  assign prog_fire  = dat && is_prog && (!tgt_q || half_q);
  assign erase_fire = dat && (is_perase || is_ferase);
  assign crc_upd    = dat && is_prog;
  assign crc_clr    = cmd_b2 && byte_i[7:3] == MODE_CLRCRC;
  assign load_val   = prog_fire ? CNT_W'(PROG_CYCLES) : CNT_W'(ERASE_CYCLES);

  // transaction tracking
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= 2'd1;
      kind_q <= K_NONE;
    end else if (start_i) begin
      idx_q  <= 2'd0;
      kind_q <= K_NONE;
    end else if (stop_i) begin
      idx_q  <= 2'd1;
      kind_q <= K_NONE;
    end else if (byte_valid_i) begin
      if (idx_q == 2'd0) begin
        idx_q  <= 2'd1;
        kind_q <= !accept ? K_NONE : (byte_i[1] ? K_CMD : K_DATA);
      end else if (take && idx_q != 2'd3 && !(kind_q == K_DATA && idx_q == 2'd2)) begin
        idx_q <= idx_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_NONE;
      tgt_q  <= 1'b0;
      half_q <= 1'b0;
      hi_q   <= '0;
    end else begin
      if (cmd_b2) begin
        mode_q <= byte_i[7:3];
        tgt_q  <= byte_i[0];
      end
      if (low_ld) half_q <= 1'b0;
      else if (crc_upd && tgt_q) begin
        half_q <= ~half_q;
        if (!half_q) hi_q <= byte_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_valid_o   <= 1'b0;
      ack_o         <= 1'b0;
      prog_o        <= 1'b0;
      page_erase_o  <= 1'b0;
      full_erase_o  <= 1'b0;
      rst_req_o     <= 1'b0;
      flash_addr_o  <= '0;
      flash_wdata_o <= '0;
    end else begin
      ack_valid_o  <= byte_valid_i;
      ack_o        <= take;
      prog_o       <= prog_fire;
      page_erase_o <= erase_fire && is_perase;
      full_erase_o <= erase_fire && is_ferase;
      rst_req_o    <= cmd_b2 && byte_i[7:3] == MODE_CPURST;
      if (prog_fire) begin
        flash_addr_o  <= cur_addr;
        flash_wdata_o <= tgt_q ? {hi_q, byte_i} : {8'h00, byte_i};
      end else if (erase_fire) begin
        flash_addr_o  <= er_addr;
      end
    end
  end

  assign tgt_word_o = tgt_q;
  assign busy_o     = busy;

  isp_addr_ctl u_addr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tgt_word_i   (tgt_q),
    .load_page_i  (cmd_b3),
    .load_low_i   (low_ld),
    .step_i       (prog_fire),
    .byte_i       (byte_i),
    .addr_o       (cur_addr),
    .erase_addr_o (er_addr)
  );

  isp_busy_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (prog_fire || erase_fire),
    .load_val_i (load_val),
    .busy_o     (busy)
  );

  isp_crc16 u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (crc_clr),
    .upd_i  (crc_upd),
    .data_i (byte_i),
    .crc_o  (crc_o)
  );
endmodule

// File: rtl/isp_seq_checker.sv
module isp_seq_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        byte_valid_i,
  input logic        ack_valid_o,
  input logic        ack_o,
  input logic        busy_o,
  input logic        prog_o,
  input logic        page_erase_o,
  input logic        full_erase_o,
  input logic        rst_req_o,
  input logic [15:0] crc_o
);
  a_r11_ack_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_i |=> ack_valid_o);
  a_r11_no_spurious_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_valid_i |=> !ack_valid_o);
  a_r9_busy_nack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && busy_o) |=> !ack_o);
  a_r9_strobe_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_o || page_erase_o || full_erase_o) |-> busy_o);
  a_r8_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog_o, page_erase_o, full_erase_o}));
  a_r9_nack_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_valid_o && !ack_o) |-> !(prog_o || page_erase_o || full_erase_o));
  a_r10_crc_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_valid_i |=> $stable(crc_o));
  a_r3_rst_req_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
endmodule

bind isp_seq isp_seq_checker u_isp_seq_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .byte_valid_i (byte_valid_i),
  .ack_valid_o  (ack_valid_o),
  .ack_o        (ack_o),
  .busy_o       (busy_o),
  .prog_o       (prog_o),
  .page_erase_o (page_erase_o),
  .full_erase_o (full_erase_o),
  .rst_req_o    (rst_req_o),
  .crc_o        (crc_o)
);

// File: tb/isp_seq_bench.sv
module isp_seq_bench;
  localparam int         CLK_PERIOD = 10;
  localparam logic [5:0] DEV        = 6'h28;
  localparam int         PROG_CYC   = 6;
  localparam int         ERASE_CYC  = 40;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0, stop = 1'b0, bvalid = 1'b0;
  logic [7:0]  bdata = '0;
  logic        ack_valid, ack, busy, prog, perase, ferase, tgt_word, rst_req;
  logic [15:0] faddr, fwdata, crc;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [15:0] exp_crc = 16'hFFFF;
  logic s_prog, s_pe, s_fe, s_rst;
  logic [15:0] s_addr, s_wdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  isp_seq #(.DEV_ID(DEV), .PROG_CYCLES(PROG_CYC), .ERASE_CYCLES(ERASE_CYC)) u_isp_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .byte_valid_i(bvalid), .byte_i(bdata), .ack_valid_o(ack_valid), .ack_o(ack),
    .busy_o(busy), .prog_o(prog), .page_erase_o(perase), .full_erase_o(ferase),
    .tgt_word_o(tgt_word), .flash_addr_o(faddr), .flash_wdata_o(fwdata),
    .rst_req_o(rst_req), .crc_o(crc)
  );

  function automatic logic [15:0] crc_ref(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      logic fb = r[15] ^ d[i];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic mark(input bit is_start);
    @(negedge clk);
    if (is_start) start = 1'b1; else stop = 1'b1;
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input bit exp_ack, input string tag);
    @(negedge clk);
    bvalid = 1'b1; bdata = b;
    @(negedge clk);
    bvalid = 1'b0;
    s_prog = prog; s_pe = perase; s_fe = ferase; s_rst = rst_req;
    s_addr = faddr; s_wdata = fwdata;
    chk(ack_valid === 1'b1, "R11 ack_valid", 32'(ack_valid), 32'd1);
    chk(ack === exp_ack, tag, 32'(ack), 32'(exp_ack));
  endtask

  task automatic cmd_write(input logic [4:0] code, input bit tgt, input logic [7:0] page);
    mark(1);
    send({DEV, 2'b10}, 1, "R2 cmd id");
    send({code, 2'b00, tgt}, 1, "R3 cmd mode");
    send(page, 1, "R4 page");
    mark(0);
  endtask

  task automatic t_reset;
    chk(crc === 16'hFFFF, "R1 crc seed", 32'(crc), 32'hFFFF);
    chk(busy === 1'b0, "R1 busy", 32'(busy), 0);
    chk({ack_valid, prog, perase, ferase, rst_req} === 5'b0, "R1 outputs idle",
        32'({ack_valid, prog, perase, ferase, rst_req}), 0);
  endtask

  task automatic t_no_mode;
    mark(1);
    send({DEV, 2'b00}, 1, "R2 data id");
    send(8'h10, 1, "R5 low");
    send(8'hAA, 0, "R12 data nacked without mode");
    chk(s_prog === 1'b0, "R12 no strobe", 32'(s_prog), 0);
    chk(crc === exp_crc, "R12 crc untouched", 32'(crc), 32'(exp_crc));
    mark(0);
  endtask

  task automatic t_bad_id;
    mark(1);
    send({DEV ^ 6'h01, 2'b10}, 0, "R2 wrong id nacked");
    send({5'b10100, 3'b000}, 0, "R2 rest nacked");
    mark(1);
    send({DEV, 2'b01}, 0, "R2 bad kind nacked");
    mark(0);
  endtask

  task automatic t_prog_code;
    mark(1);
    send({DEV, 2'b10}, 1, "R2 cmd id");
    send({5'b10100, 3'b000}, 1, "R3 program code");
    send(8'h12, 1, "R4 page");
    send(8'h99, 0, "R4 fourth byte nacked");
    mark(0);
    mark(1);
    send({DEV, 2'b00}, 1, "R2 data id");
    send(8'hFE, 1, "R5 low");
    chk(crc === exp_crc, "R5 low not in crc", 32'(crc), 32'(exp_crc));
    send(8'hA5, 1, "R6 byte0");
    exp_crc = crc_ref(exp_crc, 8'hA5);
    chk(s_prog && s_addr === 16'h12FE && s_wdata === 16'h00A5, "R6 strobe0",
        {s_addr, s_wdata}, {16'h12FE, 16'h00A5});
    chk(busy === 1'b1, "R9 busy after prog", 32'(busy), 1);
    send(8'h3C, 0, "R9 busy byte nacked");
    chk(s_prog === 1'b0, "R9 no strobe when busy", 32'(s_prog), 0);
    chk(crc === exp_crc, "R9 crc skips nacked", 32'(crc), 32'(exp_crc));
    idle(PROG_CYC);
    send(8'h3C, 1, "R6 byte1");
    exp_crc = crc_ref(exp_crc, 8'h3C);
    chk(s_prog && s_addr === 16'h12FF, "R9 addr not stepped by nack", 32'(s_addr), 32'h12FF);
    idle(PROG_CYC);
    send(8'h77, 1, "R6 byte2");
    exp_crc = crc_ref(exp_crc, 8'h77);
    chk(s_prog && s_addr === 16'h1200, "R6 low wraps no carry", 32'(s_addr), 32'h1200);
    chk(crc === exp_crc, "R10 crc code burst", 32'(crc), 32'(exp_crc));
    mark(0);
    idle(PROG_CYC);
  endtask

  task automatic t_clr_crc;
    mark(1);
    send({DEV, 2'b10}, 1, "R2 cmd id");
    send({5'b11010, 3'b000}, 1, "R3 clear crc");
    mark(0);
    exp_crc = 16'hFFFF;
    chk(crc === 16'hFFFF, "R3 crc cleared", 32'(crc), 32'hFFFF);
  endtask

  task automatic t_prog_word;
    cmd_write(5'b10100, 1'b1, 8'h85);
    chk(tgt_word === 1'b1, "R3 target word", 32'(tgt_word), 1);
    mark(1);
    send({DEV, 2'b00}, 1, "R2 data id");
    send(8'hFF, 1, "R5 word low");
    send(8'h12, 1, "R7 hi byte");
    exp_crc = crc_ref(exp_crc, 8'h12);
    chk(s_prog === 1'b0, "R7 no strobe on hi", 32'(s_prog), 0);
    send(8'h34, 1, "R7 lo byte");
    exp_crc = crc_ref(exp_crc, 8'h34);
    chk(s_prog && s_addr === 16'h02FF && s_wdata === 16'h1234, "R7 word strobe",
        {s_addr, s_wdata}, {16'h02FF, 16'h1234});
    idle(PROG_CYC);
    send(8'h56, 1, "R7 hi byte2");
    exp_crc = crc_ref(exp_crc, 8'h56);
    send(8'h78, 1, "R7 lo byte2");
    exp_crc = crc_ref(exp_crc, 8'h78);
    chk(s_prog && s_addr === 16'h0280 && s_wdata === 16'h5678, "R7 wrap in 7 bits",
        {s_addr, s_wdata}, {16'h0280, 16'h5678});
    chk(crc === exp_crc, "R10 crc word burst", 32'(crc), 32'(exp_crc));
    mark(0);
    idle(PROG_CYC);
  endtask

  task automatic t_page_erase;
    cmd_write(5'b00110, 1'b0, 8'h40);
    mark(1);
    send({DEV, 2'b00}, 1, "R2 data id");
    send(8'h33, 1, "R5 low");
    send(8'hC3, 1, "R8 erase byte");
    chk(s_pe && !s_prog && s_addr === 16'h4000, "R8 page erase strobe", 32'(s_addr), 32'h4000);
    chk(crc === exp_crc, "R8 erase byte not in crc", 32'(crc), 32'(exp_crc));
    mark(0);
    mark(1);
    send({DEV, 2'b10}, 0, "R9 cmd refused while erasing");
    chk(busy === 1'b1, "R9 busy during erase", 32'(busy), 1);
    mark(0);
    idle(ERASE_CYC);
    chk(busy === 1'b0, "R9 busy released", 32'(busy), 0);
  endtask

  task automatic t_full_erase;
    cmd_write(5'b01101, 1'b0, 8'h00);
    mark(1);
    send({DEV, 2'b00}, 1, "R2 data id");
    send(8'h00, 1, "R5 low");
    send(8'h5A, 1, "R8 blank byte");
    chk(s_fe && !s_pe, "R8 full erase strobe", 32'({s_fe, s_pe}), 32'b10);
    mark(0);
    idle(ERASE_CYC);
  endtask

  task automatic t_cpu_rst;
    mark(1);
    send({DEV, 2'b10}, 1, "R2 cmd id");
    send({5'b01001, 3'b000}, 1, "R3 cpu reset");
    chk(s_rst === 1'b1, "R3 reset pulse", 32'(s_rst), 1);
    @(negedge clk);
    chk(rst_req === 1'b0, "R3 reset one cycle", 32'(rst_req), 0);
    mark(0);
    mark(1);
    send({DEV, 2'b00}, 1, "R2 data id");
    send(8'h01, 1, "R5 low");
    send(8'h11, 0, "R12 data nacked in reset mode");
    mark(0);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_no_mode();
    t_bad_id();
    t_prog_code();
    t_clr_crc();
    t_prog_word();
    t_page_erase();
    t_full_erase();
    t_cpu_rst();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule